// File: doc/BRIEF.md
# Wake-up event router

This block gathers twenty event lines (eighteen implemented, two reserved) into one registered wake-up request. Each event line passes through a two-flop synchroniser. It is then compared against a per-bit detection mode, which is one of: low level, high level, falling edge or rising edge. A detected event latches a sticky pending flag, and the pending flags are ANDed with per-bit enables to form the request.

Software uses a word-addressed register bus with a write strobe and a one-cycle read latency. The two mode registers are plain read/write storage. The pending and enable vectors are read-only views and are changed only by dedicated write-one strobes: one to set and one to clear each vector. Every pending flag comes out of reset already raised, so software must clear the pending flags before it grants enables. Otherwise the request fires at once.

Top module: `wake_evt_router`

## Requirements
- R1: After reset the pending view (address 2) reads 0x9FFFF, the enable view (address 3) and both mode registers (addresses 0 and 1) read 0, and `wake_req` is 0.
- R2: Only bit positions 0 to 16 and 19 are implemented; bits 17 and 18 read as 0 in every register and ignore writes.
- R3: Address 0 holds the polarity bits and address 1 holds the edge-select bits; both are read/write and read back what was written (implemented bits only).
- R4: Detection per bit is coded {edge-select, polarity}: 00 low level, 01 high level, 10 falling edge, 11 rising edge; a change on `evt_in` sets the pending bit at the third rising clock edge after the change, and an idle input sets nothing.
- R5: In a level mode the pending bit is set again on every cycle the level stays active; in an edge mode only the selected edge sets it, and the opposite edge does not.
- R6: Writing 1s to address 7 clears those pending bits and writing 0s changes nothing; an event detected in the same cycle as the clear wins.
- R7: Writing 1s to address 6 forces those pending bits to 1.
- R8: Writing 1s to address 4 sets enable bits, writing 1s to address 5 clears them, and 0 bits written to either leave the enable view unchanged.
- R9: `wake_req` is the OR over implemented bits of (pending AND enable), registered once, so it follows a pending or enable change by one clock.
- R10: `bus_rdata` is registered from `bus_addr` one clock after the address is presented; addresses 4 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 20 | Asynchronous event lines |
| bus_addr | input | 3 | Word address of the register accessed |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 20 | Write data |
| bus_rdata | output | 20 | Read data, one clock after the address |
| wake_req | output | 1 | Combined wake-up request |

## Verification
Every implemented bit is driven through all four detection modes while the other bits are held idle. A single pending bit at the expected position separates the modes and shows there is no crosstalk between lanes. In the edge modes the bench applies the opposite edge after a clear, which separates edge detection from level detection. In the level modes it clears while the level is still active, which exposes whether the event wins over a same-cycle clear. Writes of all ones and of zero words to each strobe register separate the reserved bits, the no-effect zero bits and the set/clear semantics. Toggling one enable against one pending bit shows the one-clock lag of the request.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;
  localparam int unsigned EVT_W  = 20;
  localparam int unsigned ADDR_W = 3;
  localparam logic [EVT_W-1:0] EVT_MASK = 20'h9FFFF;

  typedef enum logic [ADDR_W-1:0] {
    A_POL    = 3'd0,
    A_EDGE   = 3'd1,
    A_PEND   = 3'd2,
    A_ENVIEW = 3'd3,
    A_EN_SET = 3'd4,
    A_EN_CLR = 3'd5,
    A_PD_SET = 3'd6,
    A_PD_CLR = 3'd7
  } reg_sel_e;

  // One lane's detection: edge_sel picks edge vs level, pol picks high/rising.
  function automatic logic evt_match(input logic edge_sel, input logic pol,
                                     input logic now_v, input logic before_v);
    if (edge_sel) return pol ? (now_v & ~before_v) : (~now_v & before_v);
    return pol ? now_v : ~now_v;
  endfunction

  // Next pending vector: clear, then set, then detected events; masked.
  function automatic logic [EVT_W-1:0] pend_next(input logic [EVT_W-1:0] cur,
      input logic [EVT_W-1:0] clr, input logic [EVT_W-1:0] set,
      input logic [EVT_W-1:0] hit, input logic [EVT_W-1:0] mask);
    return ((cur & ~clr) | set | hit) & mask;
  endfunction
endpackage

// File: rtl/wake_evt_sync.sv
module wake_evt_sync #(
  parameter int unsigned W      = 20,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][W-1:0] chain_q;
  logic [W-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], async_i};
      prev_q  <= chain_q[LAST];
    end
  end

  assign sync_o = chain_q[LAST];
  assign prev_o = prev_q;
endmodule

// File: rtl/wake_evt_detect.sv
module wake_evt_detect
  import wake_evt_pkg::*;
#(
  parameter int unsigned   W    = 20,
  parameter logic [W-1:0]  MASK = '1
) (
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] now_i,
  input  logic [W-1:0] before_i,
  output logic [W-1:0] hit_o
);
  for (genvar i = 0; i < W; i++) begin : g_lane
    if (MASK[i]) begin : g_impl
      assign hit_o[i] = evt_match(edge_i[i], pol_i[i], now_i[i], before_i[i]);
    end else begin : g_rsvd
      assign hit_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/wake_evt_regs.sv
module wake_evt_regs
  import wake_evt_pkg::*;
#(
  parameter int unsigned  W      = 20,
  parameter int unsigned  AW     = 3,
  parameter logic [W-1:0] MASK   = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  hit_i,
  output logic [W-1:0]  pol_o,
  output logic [W-1:0]  edge_o,
  output logic [W-1:0]  pend_o,
  output logic [W-1:0]  en_o,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] pol_q, edge_q, pend_q, en_q, rdata_q, rd_mux;
  logic [W-1:0] en_set_v, en_clr_v, pd_set_v, pd_clr_v;
  logic         wr_pol, wr_edge;

  assign wr_pol   = we_i && (addr_i == A_POL);
  assign wr_edge  = we_i && (addr_i == A_EDGE);
  assign en_set_v = (we_i && (addr_i == A_EN_SET)) ? wdata_i : '0;
  assign en_clr_v = (we_i && (addr_i == A_EN_CLR)) ? wdata_i : '0;
  assign pd_set_v = (we_i && (addr_i == A_PD_SET)) ? wdata_i : '0;
  assign pd_clr_v = (we_i && (addr_i == A_PD_CLR)) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      edge_q <= '0;
      pend_q <= MASK;
      en_q   <= '0;
    end else begin
      if (wr_pol)  pol_q  <= wdata_i & MASK;
      if (wr_edge) edge_q <= wdata_i & MASK;
      pend_q <= pend_next(pend_q, pd_clr_v, pd_set_v, hit_i, MASK);
      en_q   <= ((en_q & ~en_clr_v) | en_set_v) & MASK;
    end
  end

  always_comb begin
    case (addr_i)
      A_POL:    rd_mux = pol_q;
      A_EDGE:   rd_mux = edge_q;
      A_PEND:   rd_mux = pend_q;
      A_ENVIEW: rd_mux = en_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_mux;
  end

  assign pol_o   = pol_q;
  assign edge_o  = edge_q;
  assign pend_o  = pend_q;
  assign en_o    = en_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/wake_evt_router.sv
module wake_evt_router
  import wake_evt_pkg::*;
#(
  parameter int unsigned      EVT_N       = wake_evt_pkg::EVT_W,
  parameter int unsigned      AW          = wake_evt_pkg::ADDR_W,
  parameter logic [EVT_N-1:0] LANE_MASK   = wake_evt_pkg::EVT_MASK,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] evt_in,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [EVT_N-1:0] bus_wdata,
  output logic [EVT_N-1:0] bus_rdata,
  output logic             wake_req
);
  logic [EVT_N-1:0] evt_now, evt_before, evt_hit;
  logic [EVT_N-1:0] pol_q, edge_q, pend_q, en_q;
  logic             wake_d, wake_q;

  wake_evt_sync #(.W(EVT_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(evt_in),
    .sync_o(evt_now), .prev_o(evt_before)
  );

  wake_evt_detect #(.W(EVT_N), .MASK(LANE_MASK)) u_detect (
    .pol_i(pol_q), .edge_i(edge_q), .now_i(evt_now),
    .before_i(evt_before), .hit_o(evt_hit)
  );

  wake_evt_regs #(.W(EVT_N), .AW(AW), .MASK(LANE_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .we_i(bus_we),
    .wdata_i(bus_wdata), .hit_i(evt_hit), .pol_o(pol_q), .edge_o(edge_q),
    .pend_o(pend_q), .en_o(en_q), .rdata_o(bus_rdata)
  );

  assign wake_d = |(pend_q & en_q & LANE_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake_req = wake_q;
endmodule

// File: rtl/wake_evt_router_chk.sv
module wake_evt_router_chk
  import wake_evt_pkg::*;
#(
  parameter int unsigned  W    = 20,
  parameter int unsigned  AW   = 3,
  parameter logic [W-1:0] MASK = '1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  bus_rdata,
  input logic          wake_req,
  input logic [W-1:0]  hit,
  input logic [W-1:0]  pend,
  input logic [W-1:0]  en,
  input logic [W-1:0]  pol,
  input logic [W-1:0]  edg
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend | en | pol | edg | hit) & ~MASK) == '0);

  a_r5_hit_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pend & $past(hit)) == $past(hit)));

  a_r6_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PD_CLR) |=> ((pend & $past(bus_wdata & ~hit & MASK)) == '0));

  a_r7_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_PD_SET) |=>
      ((pend & $past(bus_wdata & MASK)) == $past(bus_wdata & MASK)));

  a_r8_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_EN_SET) |=>
      ((en & $past(bus_wdata & MASK)) == $past(bus_wdata & MASK)));

  a_r9_wake_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wake_req == $past(|(pend & en))));

  a_r10_strobe_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr >= A_EN_SET) |=> (bus_rdata == '0));
endmodule

bind wake_evt_router wake_evt_router_chk #(.W(EVT_N), .AW(AW), .MASK(LANE_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_req(wake_req),
  .hit(evt_hit), .pend(pend_q), .en(en_q), .pol(pol_q), .edg(edge_q)
);

// File: tb/wake_evt_router_tb.sv
module wake_evt_router_tb_top;
  localparam int W = 20;
  localparam logic [W-1:0] IMPL = 20'h9FFFF;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] evt = '1;
  logic [2:0]   addr = 3'd0;
  logic         we = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic         wake;
  int           n_chk = 0;
  int           n_bad = 0;

  always #5 clk = ~clk;

  wake_evt_router dut_i (
    .clk(clk), .rst_n(rst_n), .evt_in(evt), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .wake_req(wake)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 wake", {31'd0, wake}, 32'd0);
    rd(3'd2, v); check("R1 pending", {12'd0, v}, {12'd0, IMPL});
    rd(3'd3, v); check("R1 enable", {12'd0, v}, 32'd0);
    rd(3'd0, v); check("R1 polarity", {12'd0, v}, 32'd0);
    rd(3'd1, v); check("R1 edge", {12'd0, v}, 32'd0);
    // R10 strobe addresses read zero
    for (int a = 4; a < 8; a++) begin
      rd(a[2:0], v); check("R10 strobe read", {12'd0, v}, 32'd0);
    end
    // R3 / R2 mode registers
    wr(3'd0, '1); rd(3'd0, v); check("R3 R2 polarity all ones", {12'd0, v}, {12'd0, IMPL});
    wr(3'd0, '0);
    wr(3'd1, 20'hA5A5A); rd(3'd1, v); check("R3 edge pattern", {12'd0, v}, {12'd0, 20'hA5A5A & IMPL});
    wr(3'd1, '0);
    idle(4);
    // R6 / R7 / R2 pending strobes
    wr(3'd7, '1); rd(3'd2, v); check("R6 clear all", {12'd0, v}, 32'd0);
    wr(3'd6, 20'h60000); rd(3'd2, v); check("R2 reserved set ignored", {12'd0, v}, 32'd0);
    wr(3'd6, 20'h00021); rd(3'd2, v); check("R7 set", {12'd0, v}, 32'h21);
    wr(3'd7, '0); rd(3'd2, v); check("R6 zero clear no effect", {12'd0, v}, 32'h21);
    wr(3'd7, 20'h00001); rd(3'd2, v); check("R6 single clear", {12'd0, v}, 32'h20);
    // R8 / R9 enable and request
    check("R9 no enable no request", {31'd0, wake}, 32'd0);
    wr(3'd4, 20'h00020); idle(2);
    check("R9 request rises", {31'd0, wake}, 32'd1);
    rd(3'd3, v); check("R8 enable set", {12'd0, v}, 32'h20);
    wr(3'd5, '0); rd(3'd3, v); check("R8 zero clear no effect", {12'd0, v}, 32'h20);
    wr(3'd4, 20'h40000); rd(3'd3, v); check("R2 reserved enable ignored", {12'd0, v}, 32'h20);
    wr(3'd5, 20'h00020); idle(2);
    check("R9 request falls", {31'd0, wake}, 32'd0);
    rd(3'd3, v); check("R8 enable clear", {12'd0, v}, 32'd0);
    wr(3'd7, '1);
    wr(3'd4, '1);
    // R4 / R5 / R6 sweep: every implemented lane, every mode
    for (int i = 0; i < W; i++) begin
      if (!IMPL[i]) continue;
      for (int m = 0; m < 4; m++) begin
        logic l, e;
        logic [W-1:0] bit_i;
        l = m[0]; e = m[1];
        bit_i = '0; bit_i[i] = 1'b1;
        @(negedge clk); evt[i] = ~l;
        wr(3'd0, l ? bit_i : '0);
        wr(3'd1, e ? bit_i : '0);
        idle(4);
        wr(3'd7, '1);
        rd(3'd2, v); check("R4 idle input sets nothing", {12'd0, v}, 32'd0);
        @(negedge clk); evt[i] = l;
        idle(4);
        rd(3'd2, v); check("R4 event detected", {12'd0, v}, {12'd0, bit_i});
        check("R9 request on event", {31'd0, wake}, 32'd1);
        wr(3'd7, bit_i);
        rd(3'd2, v);
        if (e) check("R5 edge clears once", {12'd0, v}, 32'd0);
        else   check("R6 R5 active level wins over clear", {12'd0, v}, {12'd0, bit_i});
        @(negedge clk); evt[i] = ~l;
        idle(4);
        if (!e) wr(3'd7, bit_i);
        rd(3'd2, v); check("R5 opposite edge or idle level", {12'd0, v}, 32'd0);
        idle(1);
        check("R9 request gone", {31'd0, wake}, 32'd0);
        @(negedge clk); evt[i] = 1'b1;
        wr(3'd0, '0);
        wr(3'd1, '0);
        idle(4);
        wr(3'd7, '1);
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule